// File: doc/BRIEF.md
# Prescaled Timer with Match and Capture

This block is a general-purpose timer/counter for a peripheral subsystem, reached through a small word-addressed register port. A prescale counter divides the clock. Each time it wraps, it advances a main count. A mode register can instead make the main count follow edges of one of the capture inputs.

Four match channels compare the main count against programmed values. When a match coincides with a count tick, a channel can raise an interrupt flag, restart the count from zero, and stop the timer. Each channel can do any combination of these. Capture channels synchronise an external input and copy the main count into a capture register on a chosen edge. A capture can also raise an interrupt flag.

All flags sit in one register that software clears by writing ones to it. A single interrupt line reports whether any flag is pending. A per-channel level output shows when the count equals each match value.

Top module: `tick_match_timer`

## Requirements
- R1: After reset every register reads 0, `irq_o` is 0 and `match_o` is all ones, because a count of 0 equals every match value of 0.
- R2: In timer mode (MODE[1:0]=0) with the timer running, the prescale counter (address 4) steps from 0 up to the prescale limit (address 3). On the edge where it already equals the limit, it returns to 0 and the count (address 2) increments. The count therefore advances once every limit+1 cycles.
- R3: The control register (address 1) has bit 0 = run and bit 1 = hold. While hold is set, the count and the prescale counter are forced to 0, and hold wins over run and over bus writes. With run at 0 both counters keep their values. The edge that writes run to 0 still applies the tick computed from the old setting.
- R4: Match values sit at addresses 8 to 11 for channels 0 to 3. The match control register (address 5) gives channel k bit 3k = flag, bit 3k+1 = restart and bit 3k+2 = stop. On a count tick where the count equals match value k and bit 3k is set, flag bit k is set.
- R5: With the restart bit set, a matching tick loads 0 into the count instead of incrementing it, and sets the flag on that same edge. The count therefore cycles through match value + 1 states.
- R6: With the stop bit set, a matching tick clears the run bit. The count keeps the match value and the prescale counter wraps to 0. Both then hold until run is written to 1 again.
- R7: The capture control register (address 6) gives input `cap_i[j]` bit 3j = rising, bit 3j+1 = falling and bit 3j+2 = flag. On a selected edge, capture register j (address 12+j) loads the count on the third rising clock edge after the pin changes. If the flag bit is set, flag bit 4+j is set on that same edge. Unselected edges leave the capture register unchanged.
- R8: Writing the flag register (address 0) clears each bit written as 1 and leaves each bit written as 0 unchanged. A new event on the same edge wins over a clear. `irq_o` is high while any flag is set.
- R9: In counter mode, the count takes one tick per rising edge (MODE[1:0]=1), falling edge (2) or both edges (3) of input `cap_i[MODE[3:2]]`. The tick lands on the third clock edge after the pin changes, and the prescale counter holds its value.
- R10: The count and the prescale counter can be written over the bus. The written value holds after the write edge, and counting continues from it.
- R11: `match_o[k]` is high exactly while the count equals match value k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address for writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cap_i | input | NUM_CAP | Capture / count inputs, asynchronous |
| irq_o | output | 1 | High while any flag is pending |
| match_o | output | NUM_MATCH | Count equals match value, per channel |

## Verification
A bus write lands on the edge that samples the strobe, and so does a count tick, a match action and its flag. The bench therefore reads the registers 1 ns after that edge, through the combinational read port. Each result that depends on a pin arrives on the third clock edge after the pin changes: this covers captures, counter-mode ticks and capture flags. Pins are driven at falling edges, and the capture tests read once after the second rising edge (old value still expected) and again after the third (new value expected). Timer-mode expectations are computed from the number of edges since the enabling write, using the prescale limit and the match value.

// File: rtl/tmr_pkg.sv
// Shared register addresses and mode encodings for the tick/match timer.
// Assumes a 4-bit word address space with at most four match and four
// capture channels.
package tmr_pkg;
    localparam logic [3:0] RA_FLAGS  = 4'd0;
    localparam logic [3:0] RA_CTRL   = 4'd1;
    localparam logic [3:0] RA_COUNT  = 4'd2;
    localparam logic [3:0] RA_PLIM   = 4'd3;
    localparam logic [3:0] RA_PCNT   = 4'd4;
    localparam logic [3:0] RA_MCTL   = 4'd5;
    localparam logic [3:0] RA_CCTL   = 4'd6;
    localparam logic [3:0] RA_MODE   = 4'd7;
    localparam logic [3:0] RA_MATCH0 = 4'd8;
    localparam logic [3:0] RA_CAP0   = 4'd12;

    typedef enum logic [1:0] {
        CM_TIMER = 2'd0,
        CM_RISE  = 2'd1,
        CM_FALL  = 2'd2,
        CM_BOTH  = 2'd3
    } cnt_mode_e;
endpackage

// File: rtl/tmr_edge.sv
// Two-flop synchroniser plus edge detector for each asynchronous input lane.
// Edge pulses are one cycle long and come from the synchronised level.
module tmr_edge #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] pin_i,
    output logic [LANES-1:0] rise_o,
    output logic [LANES-1:0] fall_o
);
    logic [LANES-1:0] sync1_q, sync2_q, prev_q;

    // Synchronise the pins and keep the previous synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
        end else begin
            sync1_q <= pin_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign rise_o = sync2_q & ~prev_q;
    assign fall_o = ~sync2_q & prev_q;
endmodule

// File: rtl/tmr_prescale.sv
// Prescale counter: counts up to the limit and wraps, giving a tick on the
// cycle where it equals the limit. Clear wins over write, write over counting.
module tmr_prescale #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         run_i,
    input  logic         wr_i,
    input  logic [W-1:0] wr_val_i,
    input  logic [W-1:0] limit_i,
    output logic [W-1:0] pc_o,
    output logic         tick_o
);
    localparam logic [W-1:0] ONE = W'(1);
    logic [W-1:0] pc_q;

    assign tick_o = run_i && (pc_q == limit_i);
    assign pc_o   = pc_q;

    // Advance, wrap, load or clear the prescale count.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_q <= '0;
        else if (clr_i)  pc_q <= '0;
        else if (wr_i)   pc_q <= wr_val_i;
        else if (run_i)  pc_q <= tick_o ? '0 : pc_q + ONE;
    end
endmodule

// File: rtl/tmr_match.sv
// Match comparators: per channel equality against the count, and the
// selected actions for a tick that lands on a match. Purely combinational.
module tmr_match #(
    parameter int W = 16,
    parameter int N = 4
) (
    input  logic [W-1:0]   tc_i,
    input  logic [W-1:0]   mv_i [N],
    input  logic [3*N-1:0] ctl_i,
    input  logic           tick_i,
    output logic [N-1:0]   hit_o,
    output logic [N-1:0]   irq_o,
    output logic           restart_o,
    output logic           stop_o
);
    logic [N-1:0] restart_v, stop_v;

    for (genvar k = 0; k < N; k++) begin : g_ch
        assign hit_o[k]     = (tc_i == mv_i[k]);
        assign irq_o[k]     = tick_i && hit_o[k] && ctl_i[3*k];
        assign restart_v[k] = tick_i && hit_o[k] && ctl_i[3*k+1];
        assign stop_v[k]    = tick_i && hit_o[k] && ctl_i[3*k+2];
    end

    assign restart_o = |restart_v;
    assign stop_o    = |stop_v;
endmodule

// File: rtl/tick_match_timer.sv
// Prescaled timer/counter with four match channels and edge captures.
// Assumes CNT_W <= 32, NUM_MATCH <= 4 and 2 <= NUM_CAP <= 4 (address map).
module tick_match_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int NUM_MATCH = 4,
    parameter int NUM_CAP   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [3:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_CAP-1:0]   cap_i,
    output logic                 irq_o,
    output logic [NUM_MATCH-1:0] match_o
);
    localparam int IRQ_W  = NUM_MATCH + NUM_CAP;
    localparam int MCTL_W = 3 * NUM_MATCH;
    localparam int CCTL_W = 3 * NUM_CAP;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [1:0]        ctrl_q;
    logic [3:0]        mode_q;
    logic [CNT_W-1:0]  tc_q, pr_q, pc_w;
    logic [MCTL_W-1:0] mctl_q;
    logic [CCTL_W-1:0] cctl_q;
    logic [CNT_W-1:0]  mv_q [NUM_MATCH];
    logic [CNT_W-1:0]  cv_q [NUM_CAP];
    logic [IRQ_W-1:0]  flags_q;

    logic [CNT_W-1:0]   wval;
    logic               hold, running, pre_tick, cnt_tick, m_restart, m_stop;
    logic [NUM_CAP-1:0] rise_v, fall_v, cap_ev, cap_irq;
    logic [3:0]         rise_pad, fall_pad;
    logic [NUM_MATCH-1:0] m_irq;
    cnt_mode_e          mode;

    assign wval    = bus_wdata[CNT_W-1:0];
    assign hold    = ctrl_q[1];
    assign running = ctrl_q[0] && !hold;
    assign mode    = cnt_mode_e'(mode_q[1:0]);

    if (CNT_W < 32) begin : g_wsink
        logic wdata_unused;
        assign wdata_unused = ^bus_wdata[31:CNT_W];
    end

    tmr_edge #(.LANES(NUM_CAP)) edge_i (
        .clk(clk), .rst_n(rst_n), .pin_i(cap_i), .rise_o(rise_v), .fall_o(fall_v)
    );

    tmr_prescale #(.W(CNT_W)) pre_i (
        .clk(clk), .rst_n(rst_n), .clr_i(hold),
        .run_i(running && mode == CM_TIMER),
        .wr_i(bus_we && bus_addr == RA_PCNT), .wr_val_i(wval),
        .limit_i(pr_q), .pc_o(pc_w), .tick_o(pre_tick)
    );

    tmr_match #(.W(CNT_W), .N(NUM_MATCH)) match_i (
        .tc_i(tc_q), .mv_i(mv_q), .ctl_i(mctl_q), .tick_i(cnt_tick),
        .hit_o(match_o), .irq_o(m_irq), .restart_o(m_restart), .stop_o(m_stop)
    );

    assign rise_pad = 4'(rise_v);
    assign fall_pad = 4'(fall_v);

    // Choose the count tick source for the selected mode.
    always_comb begin
        unique case (mode)
            CM_TIMER: cnt_tick = pre_tick;
            CM_RISE:  cnt_tick = running && rise_pad[mode_q[3:2]];
            CM_FALL:  cnt_tick = running && fall_pad[mode_q[3:2]];
            default:  cnt_tick = running && (rise_pad[mode_q[3:2]] || fall_pad[mode_q[3:2]]);
        endcase
    end

    for (genvar j = 0; j < NUM_CAP; j++) begin : g_cap
        assign cap_ev[j]  = (cctl_q[3*j] && rise_v[j]) || (cctl_q[3*j+1] && fall_v[j]);
        assign cap_irq[j] = cap_ev[j] && cctl_q[3*j+2];
    end

    // Configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr_q   <= '0;
            mctl_q <= '0;
            cctl_q <= '0;
            mode_q <= '0;
            for (int k = 0; k < NUM_MATCH; k++) mv_q[k] <= '0;
        end else if (bus_we) begin
            if (bus_addr == RA_PLIM) pr_q   <= wval;
            if (bus_addr == RA_MCTL) mctl_q <= bus_wdata[MCTL_W-1:0];
            if (bus_addr == RA_CCTL) cctl_q <= bus_wdata[CCTL_W-1:0];
            if (bus_addr == RA_MODE) mode_q <= bus_wdata[3:0];
            for (int k = 0; k < NUM_MATCH; k++)
                if (bus_addr == RA_MATCH0 + 4'(k)) mv_q[k] <= wval;
        end
    end

    // Control register; a stop-on-match clears run after any bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else begin
            if (bus_we && bus_addr == RA_CTRL) ctrl_q <= bus_wdata[1:0];
            if (cnt_tick && m_stop) ctrl_q[0] <= 1'b0;
        end
    end

    // Main count: hold, bus load, restart, stop or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)                              tc_q <= '0;
        else if (hold)                           tc_q <= '0;
        else if (bus_we && bus_addr == RA_COUNT) tc_q <= wval;
        else if (cnt_tick) begin
            if (m_restart)   tc_q <= '0;
            else if (!m_stop) tc_q <= tc_q + ONE;
        end
    end

    // Capture registers load the count on their selected edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NUM_CAP; j++) cv_q[j] <= '0;
        end else begin
            for (int j = 0; j < NUM_CAP; j++)
                if (cap_ev[j]) cv_q[j] <= tc_q;
        end
    end

    // Flags: write-one-to-clear, with new events taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else flags_q <= (flags_q & ~((bus_we && bus_addr == RA_FLAGS) ? bus_wdata[IRQ_W-1:0] : '0))
                        | {cap_irq, m_irq};
    end

    assign irq_o = |flags_q;

    // Combinational read mux over the register map.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_FLAGS: bus_rdata = 32'(flags_q);
            RA_CTRL:  bus_rdata = 32'(ctrl_q);
            RA_COUNT: bus_rdata = 32'(tc_q);
            RA_PLIM:  bus_rdata = 32'(pr_q);
            RA_PCNT:  bus_rdata = 32'(pc_w);
            RA_MCTL:  bus_rdata = 32'(mctl_q);
            RA_CCTL:  bus_rdata = 32'(cctl_q);
            RA_MODE:  bus_rdata = 32'(mode_q);
            default: begin
                for (int k = 0; k < NUM_MATCH; k++)
                    if (bus_addr == RA_MATCH0 + 4'(k)) bus_rdata = 32'(mv_q[k]);
                for (int j = 0; j < NUM_CAP; j++)
                    if (bus_addr == RA_CAP0 + 4'(j)) bus_rdata = 32'(cv_q[j]);
            end
        endcase
    end
endmodule

// File: rtl/tick_match_timer_chk.sv
// Property checker for tick_match_timer, attached by bind. Observes the
// control, counters, match channel 0 and its flag.
module tick_match_timer_chk #(
    parameter int W  = 16,
    parameter int NM = 4,
    parameter int IW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_we,
    input logic [3:0]    bus_addr,
    input logic [1:0]    ctrl_q,
    input logic [3:0]    mode_q,
    input logic [W-1:0]  pc_q,
    input logic [W-1:0]  pr_q,
    input logic [W-1:0]  tc_q,
    input logic [W-1:0]  mv0,
    input logic [3*NM-1:0] mctl_q,
    input logic [IW-1:0] flags_q
);
    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[1] |=> (tc_q == '0 && pc_q == '0));  // R3

    AST_PRESCALE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q == 2'b01 && mode_q[1:0] == 2'd0 && pc_q == pr_q
         && !(bus_we && bus_addr == 4'd4)) |=> pc_q == '0);  // R2

    AST_MATCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q == 2'b01 && mode_q[1:0] == 2'd0 && pc_q == pr_q && tc_q == mv0
         && mctl_q[1] && !(bus_we && bus_addr == 4'd2)) |=> tc_q == '0);  // R5

    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q == 2'b01 && mode_q[1:0] == 2'd0 && pc_q == pr_q && tc_q == mv0
         && mctl_q[0]) |=> flags_q[0]);  // R4

    AST_STOP_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q == 2'b01 && mode_q[1:0] == 2'd0 && pc_q == pr_q && tc_q == mv0
         && mctl_q[2]) |=> !ctrl_q[0]);  // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[0] && !(bus_we && bus_addr == 4'd0)) |=> flags_q[0]);  // R8
endmodule

bind tick_match_timer tick_match_timer_chk #(
    .W(CNT_W), .NM(NUM_MATCH), .IW(IRQ_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .ctrl_q(ctrl_q), .mode_q(mode_q), .pc_q(pc_w), .pr_q(pr_q), .tc_q(tc_q),
    .mv0(mv_q[0]), .mctl_q(mctl_q), .flags_q(flags_q)
);

// File: tb/tick_match_timer_tb_top.sv
// Self-checking bench: seeded random timer/match runs plus directed cases.
module tick_match_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  cap = '0;
    logic        irq;
    logic [3:0]  match;

    int n_chk = 0;
    int n_fail = 0;

    tick_match_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_i(cap),
        .irq_o(irq), .match_o(match)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic restart_counts();
        wr(4'd1, 32'd2);
        wr(4'd1, 32'd0);
    endtask

    task automatic pulses(input int lane, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cap[lane] = 1'b1;
            repeat (2) @(negedge clk);
            cap[lane] = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    function automatic int exp_tc(input int k, input int lim);
        return k / (lim + 1);
    endfunction

    function automatic int exp_pc(input int k, input int lim);
        return k % (lim + 1);
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired before R1..R11 sequence finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d, d2;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 14; a++) begin
            rd(4'(a), d);
            chk($sformatf("R1 reg %0d after reset", a), d, 32'd0);
        end
        chk("R1 irq_o after reset", {31'd0, irq}, 32'd0);
        chk("R1 match_o after reset", {28'd0, match}, 32'hF);

        // R2: random prescale limits, count and prescale after K edges
        for (int it = 0; it < 20; it++) begin
            int lim, k;
            lim = int'($urandom % 8);
            k = 1 + int'($urandom % 40);
            restart_counts();
            wr(4'd3, 32'(lim));
            wr(4'd1, 32'd1);
            wait_edges(k);
            rd(4'd2, d); rd(4'd4, d2);
            chk("R2 count vs prescale", d, 32'(exp_tc(k, lim)));
            chk("R2 prescale counter", d2, 32'(exp_pc(k, lim)));
            wr(4'd1, 32'd0);
        end

        // R10: bus loads of count and prescale, counting resumes from them
        restart_counts();
        wr(4'd3, 32'd9);
        wr(4'd2, 32'd50);
        wr(4'd4, 32'd4);
        rd(4'd4, d);
        chk("R10 prescale write", d, 32'd4);
        wr(4'd1, 32'd1);
        wait_edges(6);
        rd(4'd2, d); rd(4'd4, d2);
        chk("R10 count after load", d, 32'd51);
        chk("R10 prescale wrap after load", d2, 32'd0);

        // R3: hold forces zero, run=0 freezes
        restart_counts();
        wr(4'd3, 32'd0);
        wr(4'd1, 32'd1);
        wait_edges(5);
        wr(4'd1, 32'd3);
        wait_edges(4);
        rd(4'd2, d); rd(4'd4, d2);
        chk("R3 hold clears count", d, 32'd0);
        chk("R3 hold clears prescale", d2, 32'd0);
        wr(4'd1, 32'd1);
        wait_edges(3);
        wr(4'd1, 32'd0);
        rd(4'd2, d);
        chk("R3 last tick on disabling edge", d, 32'd4);
        wait_edges(10);
        rd(4'd2, d);
        chk("R3 frozen while run=0", d, 32'd4);

        // R4 / R5: restart-on-match with flag, random match values
        wr(4'd5, 32'h3);
        for (int it = 0; it < 12; it++) begin
            int m, k;
            m = 1 + int'($urandom % 9);
            k = 1 + int'($urandom % 30);
            restart_counts();
            wr(4'd8, 32'(m));
            wr(4'd0, 32'hFF);
            wr(4'd1, 32'd1);
            wait_edges(k);
            rd(4'd2, d); rd(4'd0, d2);
            chk("R5 count wraps at match", d, 32'(k % (m + 1)));
            chk("R4 match flag", d2, (k >= m + 1) ? 32'd1 : 32'd0);
            wr(4'd1, 32'd0);
        end
        // R5 directed: flag on the same edge as the restart
        restart_counts();
        wr(4'd8, 32'd5);
        wr(4'd0, 32'hFF);
        wr(4'd1, 32'd1);
        wait_edges(5);
        rd(4'd0, d);
        chk("R5 no flag before match edge", d, 32'd0);
        wait_edges(1);
        rd(4'd2, d); rd(4'd0, d2);
        chk("R5 restart edge count", d, 32'd0);
        chk("R5 flag same edge as restart", d2, 32'd1);
        wr(4'd1, 32'd0);

        // R6 / R11: stop on match channel 1
        restart_counts();
        wr(4'd5, 32'h20);
        wr(4'd8, 32'd5);
        wr(4'd9, 32'd3);
        wr(4'd3, 32'd1);
        wr(4'd0, 32'hFF);
        wr(4'd1, 32'd1);
        wait_edges(20);
        rd(4'd2, d); rd(4'd4, d2);
        chk("R6 count stops at match", d, 32'd3);
        chk("R6 prescale wraps on stop", d2, 32'd0);
        rd(4'd1, d);
        chk("R6 run bit cleared", d, 32'd0);
        chk("R11 match_o while count=3", {28'd0, match}, 32'h2);
        chk("R4 no flag when flag bit clear", {31'd0, irq}, 32'd0);
        wr(4'd5, 32'h0);

        // R7: captures on input 0
        restart_counts();
        wr(4'd3, 32'd0);
        wr(4'd2, 32'd100);
        wr(4'd6, 32'h5);
        wr(4'd0, 32'hFF);
        @(negedge clk); cap[0] = 1'b1;
        wait_edges(2);
        rd(4'd12, d);
        chk("R7 capture not before third edge", d, 32'd0);
        wait_edges(1);
        rd(4'd12, d); rd(4'd0, d2);
        chk("R7 rising capture", d, 32'd100);
        chk("R7 capture flag", d2, 32'h10);
        wr(4'd2, 32'd200);
        @(negedge clk); cap[0] = 1'b0;
        wait_edges(4);
        rd(4'd12, d);
        chk("R7 falling edge ignored", d, 32'd100);
        wr(4'd6, 32'h2);
        wr(4'd0, 32'hFF);
        wr(4'd2, 32'd300);
        @(negedge clk); cap[0] = 1'b1;
        wait_edges(4);
        rd(4'd12, d);
        chk("R7 rising edge ignored", d, 32'd100);
        @(negedge clk); cap[0] = 1'b0;
        wait_edges(4);
        rd(4'd12, d); rd(4'd0, d2);
        chk("R7 falling capture", d, 32'd300);
        chk("R7 no flag without flag bit", d2, 32'd0);

        // R8: write-one-to-clear flags
        wr(4'd6, 32'h5);
        @(negedge clk); cap[0] = 1'b1;
        wait_edges(4);
        wr(4'd0, 32'h0);
        rd(4'd0, d);
        chk("R8 zero write keeps flag", d, 32'h10);
        chk("R8 irq_o high", {31'd0, irq}, 32'd1);
        wr(4'd0, 32'h10);
        rd(4'd0, d);
        chk("R8 one write clears flag", d, 32'd0);
        chk("R8 irq_o low", {31'd0, irq}, 32'd0);
        wr(4'd6, 32'h0);
        @(negedge clk); cap[0] = 1'b0;

        // R9: counter mode on input 1
        for (int md = 1; md < 4; md++) begin
            int n;
            n = 1 + int'($urandom % 8);
            restart_counts();
            wr(4'd7, 32'(4 + md));
            wr(4'd3, 32'd3);
            wr(4'd4, 32'd2);
            wr(4'd1, 32'd1);
            pulses(1, n);
            wait_edges(4);
            rd(4'd2, d); rd(4'd4, d2);
            chk($sformatf("R9 edge count mode %0d", md), d, 32'((md == 3) ? 2 * n : n));
            chk("R9 prescale holds in counter mode", d2, 32'd2);
            wr(4'd1, 32'd0);
        end

        summary();
        $finish;
    end
endmodule